// File: doc/BRIEF.md
# Two-Thread Core Sharing-Mode Sequencer

This block follows which of the two hardware threads of a simultaneously multithreaded core are still running, and from that it sets how the core's shared resources are laid out. The block receives two kinds of one-cycle pulses for each thread. A halt pulse means that the thread has stopped, for example by running an idle halt. An interrupt pulse means that the thread has been woken. The block holds one of four modes:

- **DUAL**: both threads run, and the resources stay split between them.
- **SOLO0**: only thread 0 runs.
- **SOLO1**: only thread 1 runs.
- **SLEEP**: neither thread runs.

The block also drives two level outputs. One tells the resource logic to merge its split queues for the lone running thread. The other asks the power logic to enter a low-power state.

The block does not reconfigure any resource and does not gate any power itself. It only chooses the mode and signals it. A running thread that halts hands the whole core to the other thread, and the last thread to halt sends the core to SLEEP. An interrupt brings a halted thread back.

The named transitions are:

- **drop0**: DUAL to SOLO1.
- **drop1**: DUAL to SOLO0.
- **drop_both**: DUAL to SLEEP.
- **retire0**: SOLO0 to SLEEP.
- **retire1**: SOLO1 to SLEEP.
- **rejoin1**: SOLO0 to DUAL.
- **rejoin0**: SOLO1 to DUAL.
- **swap01**: SOLO0 to SOLO1.
- **swap10**: SOLO1 to SOLO0.
- **rouse0**: SLEEP to SOLO0.
- **rouse1**: SLEEP to SOLO1.
- **rouse_both**: SLEEP to DUAL.

Top module: `smt_mode_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `mode` is DUAL (2'b00), `merge_req` is 0 and `sleep_req` is 0. The mode encoding is DUAL=2'b00, SOLO0=2'b01, SOLO1=2'b10 and SLEEP=2'b11. Bit 0 of the event buses belongs to thread 0, and bit 1 to thread 1.
- R2: In DUAL, a halt pulse on thread 0 alone gives SOLO1 at the next clock edge (drop0). A halt pulse on thread 1 alone gives SOLO0 (drop1).
- R3: In DUAL, halt pulses on both threads in the same cycle give SLEEP at the next edge (drop_both).
- R4: In SOLO0, a halt pulse on thread 0 gives SLEEP (retire0). In SOLO1, a halt pulse on thread 1 gives SLEEP (retire1).
- R5: An interrupt pulse to a halted thread wakes it. From a SOLO mode this gives DUAL (rejoin0/rejoin1). From SLEEP it gives the SOLO mode of that thread (rouse0/rouse1), or DUAL when both threads are interrupted together (rouse_both).
- R6: When a thread receives a halt pulse and an interrupt pulse in the same cycle, the interrupt wins: the thread ends up running.
- R7: A halt pulse to a thread that is already halted has no effect on `mode`. An interrupt pulse to a thread that is running also has no effect on `mode`.
- R8: In a SOLO mode, waking the halted thread while the running thread halts, in the same cycle, gives the other SOLO mode (swap01/swap10).
- R9: `merge_req` is high in exactly the cycles whose previous cycle had `mode` at SOLO0 or SOLO1. It therefore rises one cycle after a SOLO mode is entered and falls one cycle after it is left.
- R10: `sleep_req` is high exactly while `mode` is SLEEP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_ev | input | 2 | Per-thread halt pulse, bit t for thread t |
| intr_ev | input | 2 | Per-thread interrupt pulse, bit t for thread t |
| mode | output | 2 | Current sharing mode (encoding in R1) |
| merge_req | output | 1 | Merge partitioned resources for the lone thread |
| sleep_req | output | 1 | Low-power request |

## Verification
The bench goes after events that arrive in the same cycle. If the two halts in DUAL were handled one after the other, the design would stop in a SOLO mode instead of SLEEP. If a halt took priority over an interrupt on the same thread, that thread would be lost. If a wake and a halt in a SOLO mode were not combined, the design would pass through DUAL or SLEEP instead of swapping threads. The bench also sends events that must be ignored, such as a halt to a halted thread or an interrupt to a running thread. A design that acted on them would drift away from the reference. In addition, the bench checks every cycle that `merge_req` trails the mode by exactly one cycle, which catches a version that is combinational or two cycles late.

// File: rtl/smt_mode_pkg.sv
package smt_mode_pkg;

    localparam int unsigned THREADS = 2;

    // Bit k set means thread (1-k) is halted.
    typedef enum logic [1:0] {
        MODE_DUAL  = 2'b00,
        MODE_SOLO0 = 2'b01,
        MODE_SOLO1 = 2'b10,
        MODE_SLEEP = 2'b11
    } smt_mode_e;

    function automatic logic thread_runs(smt_mode_e m, int unsigned t);
        logic r;
        unique case (m)
            MODE_DUAL:  r = 1'b1;
            MODE_SOLO0: r = (t == 0);
            MODE_SOLO1: r = (t == 1);
            MODE_SLEEP: r = 1'b0;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/smt_event_qualify.sv
module smt_event_qualify
    import smt_mode_pkg::*;
#(
    parameter int unsigned N = THREADS
) (
    input  smt_mode_e        cur_mode,
    input  logic [N-1:0]     halt_ev,
    input  logic [N-1:0]     intr_ev,
    output logic [N-1:0]     sleep_go,
    output logic [N-1:0]     wake_go
);

    for (genvar t = 0; t < N; t++) begin : g_thr
        logic running;
        always_comb begin
            running     = thread_runs(cur_mode, t);
            // An interrupt on the same thread overrides its halt.
            sleep_go[t] = running & halt_ev[t] & ~intr_ev[t];
            wake_go[t]  = ~running & intr_ev[t];
        end
    end

endmodule

// File: rtl/smt_mode_fsm.sv
module smt_mode_fsm
    import smt_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] halt_ev,
    input  logic [1:0] intr_ev,
    input  logic [1:0] sleep_go,
    input  logic [1:0] wake_go,
    output smt_mode_e  state
);

    smt_mode_e next_state;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= MODE_DUAL;
        else        state <= next_state;
    end

    always_comb begin
        next_state = state;
        unique case (state)
            MODE_DUAL: begin
                if (sleep_go[0] && sleep_go[1]) next_state = MODE_SLEEP;  // drop_both
                else if (sleep_go[0])           next_state = MODE_SOLO1;  // drop0
                else if (sleep_go[1])           next_state = MODE_SOLO0;  // drop1
            end
            MODE_SOLO0: begin
                if (wake_go[1] && sleep_go[0])  next_state = MODE_SOLO1;  // swap01
                else if (wake_go[1])            next_state = MODE_DUAL;   // rejoin1
                else if (sleep_go[0])           next_state = MODE_SLEEP;  // retire0
            end
            MODE_SOLO1: begin
                if (wake_go[0] && sleep_go[1])  next_state = MODE_SOLO0;  // swap10
                else if (wake_go[0])            next_state = MODE_DUAL;   // rejoin0
                else if (sleep_go[1])           next_state = MODE_SLEEP;  // retire1
            end
            MODE_SLEEP: begin
                if (wake_go[0] && wake_go[1])   next_state = MODE_DUAL;   // rouse_both
                else if (wake_go[0])            next_state = MODE_SOLO0;  // rouse0
                else if (wake_go[1])            next_state = MODE_SOLO1;  // rouse1
            end
            default: next_state = MODE_DUAL;
        endcase
    end

    // R3
    both_halt_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_DUAL && halt_ev == 2'b11 && intr_ev == 2'b00) |=> state == MODE_SLEEP);

    // R4
    last_halt_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_SOLO0 && halt_ev[0] && intr_ev == 2'b00) |=> state == MODE_SLEEP);

    // R6
    intr_beats_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_DUAL && intr_ev == 2'b11) |=> state == MODE_DUAL);

    // R7
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_SLEEP && intr_ev == 2'b00) |=> state == MODE_SLEEP);

endmodule

// File: rtl/smt_mode_outputs.sv
module smt_mode_outputs
    import smt_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  smt_mode_e state,
    output logic      merge_req,
    output logic      sleep_req
);

    logic solo_now;

    always_comb begin
        unique case (state)
            MODE_SOLO0, MODE_SOLO1: solo_now = 1'b1;
            default:                solo_now = 1'b0;
        endcase
        sleep_req = (state == MODE_SLEEP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) merge_req <= 1'b0;
        else        merge_req <= solo_now;
    end

endmodule

// File: rtl/smt_mode_ctrl.sv
module smt_mode_ctrl
    import smt_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] halt_ev,
    input  logic [1:0] intr_ev,
    output logic [1:0] mode,
    output logic       merge_req,
    output logic       sleep_req
);

    smt_mode_e  state;
    logic [1:0] sleep_go;
    logic [1:0] wake_go;

    smt_event_qualify #(.N(THREADS)) u_qual (
        .cur_mode (state),
        .halt_ev  (halt_ev),
        .intr_ev  (intr_ev),
        .sleep_go (sleep_go),
        .wake_go  (wake_go)
    );

    smt_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_ev  (halt_ev),
        .intr_ev  (intr_ev),
        .sleep_go (sleep_go),
        .wake_go  (wake_go),
        .state    (state)
    );

    smt_mode_outputs u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .merge_req (merge_req),
        .sleep_req (sleep_req)
    );

    assign mode = state;

    // R9
    merge_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(merge_req) |-> ($past(mode) == 2'b01 || $past(mode) == 2'b10));

    // R2
    drop0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && halt_ev == 2'b01 && intr_ev == 2'b00) |=> mode == 2'b10);

endmodule

// File: tb/tb_smt_mode_ctrl.sv
module tb_smt_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] halt_ev = 2'b00;
    logic [1:0] intr_ev = 2'b00;
    logic [1:0] mode;
    logic       merge_req;
    logic       sleep_req;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    int    exp_mode = 0;
    bit    exp_merge = 0;
    string pend_tag = "R1";

    always #4 clk = ~clk;   // 125 MHz

    smt_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .halt_ev(halt_ev), .intr_ev(intr_ev),
        .mode(mode), .merge_req(merge_req), .sleep_req(sleep_req)
    );

    // Reference: active set -> mode (DUAL=0, SOLO0=1, SOLO1=2, SLEEP=3)
    function automatic int ref_next(int m, logic [1:0] h, logic [1:0] i);
        bit a0, a1, n0, n1;
        a0 = (m == 0) || (m == 1);
        a1 = (m == 0) || (m == 2);
        n0 = i[0] || (a0 && !h[0]);
        n1 = i[1] || (a1 && !h[1]);
        if (n0 && n1) return 0;
        if (n0)       return 1;
        if (n1)       return 2;
        return 3;
    endfunction

    task automatic compare(string tag);
        vectors++;
        if (mode !== exp_mode[1:0] || merge_req !== exp_merge || sleep_req !== (exp_mode == 3)) begin
            errors++;
            $display("FAIL %s: mode=%0d merge=%0b sleep=%0b expected mode=%0d merge=%0b sleep=%0b",
                     tag, mode, merge_req, sleep_req, exp_mode, exp_merge, exp_mode == 3);
        end
    endtask

    // Check the outputs caused by the previous step, then apply one step.
    task automatic step(logic [1:0] h, logic [1:0] i, string tag);
        @(negedge clk);
        compare(pend_tag);
        halt_ev   = h;
        intr_ev   = i;
        exp_merge = (exp_mode == 1) || (exp_mode == 2);   // R9
        exp_mode  = ref_next(exp_mode, h, i);
        pend_tag  = tag;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1");             // R1 during reset
        @(negedge clk);
        rst_n = 1'b1;
        pend_tag = "R1";
        step(2'b00, 2'b00, "R1");  // first cycle out of reset
        step(2'b01, 2'b00, "R2");  // drop0 -> SOLO1
        step(2'b00, 2'b00, "R9");  // merge rises
        step(2'b10, 2'b00, "R4");  // retire1 -> SLEEP
        step(2'b11, 2'b00, "R7");  // halts to halted threads ignored
        step(2'b00, 2'b00, "R10"); // sleep request held
        step(2'b00, 2'b01, "R5");  // rouse0 -> SOLO0
        step(2'b00, 2'b01, "R7");  // intr to running thread ignored
        step(2'b01, 2'b01, "R6");  // intr beats halt, stays SOLO0
        step(2'b01, 2'b10, "R8");  // swap01 -> SOLO1
        step(2'b00, 2'b01, "R5");  // rejoin0 -> DUAL
        step(2'b00, 2'b00, "R9");  // merge falls
        step(2'b10, 2'b00, "R2");  // drop1 -> SOLO0
        step(2'b01, 2'b00, "R4");  // retire0 -> SLEEP
        step(2'b00, 2'b11, "R5");  // rouse_both -> DUAL
        step(2'b11, 2'b00, "R3");  // drop_both -> SLEEP
        step(2'b00, 2'b10, "R5");  // rouse1 -> SOLO1
        step(2'b10, 2'b01, "R8");  // swap10 -> SOLO0
        step(2'b00, 2'b10, "R5");  // rejoin1 -> DUAL
        step(2'b11, 2'b11, "R6");  // both halts overridden
        step(2'b10, 2'b00, "R2");
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] h, i;
            h = 2'($urandom_range(0, 3));
            i = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
            step(h, i, "R7");
        end
        step(2'b00, 2'b00, "R7");
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule